// File: doc/BRIEF.md
# PHY Master Handshake Timing Monitor

This block observes the handshake in which the physical-layer side asks the memory controller for ownership of the DFI interface. It raises a request line and later sees an acknowledge. The monitor times two phases of that exchange in DFI clock cycles. The first is how long the acknowledge takes to arrive after the request rises. The second is how long the request stays up once the acknowledge has been seen. Each phase has its own programmable limit. A limit of zero turns that check off.

The limits are stored per frequency copy, and there are `N_COPY` copies, two by default. Each copy holds one pair of limits in a single `2*LIM_W`-bit word. The copy that applies to a handshake is taken from a select input on the clock edge that first samples the request high. Each kind of violation sets its own sticky status bit. Software clears a bit by writing a one to it. The interrupt output is high while any status bit is set.

The sequencer has five states. `PH_IDLE` waits for a request. `PH_WAIT_ACK` counts response cycles. `PH_RESP_LATE` is entered after a response violation and waits for the acknowledge with no further counting. `PH_HOLD` counts hold cycles. `PH_HOLD_OVER` is entered after a hold violation and waits for the request to fall.

The transitions are as follows:
- `PH_IDLE`→`PH_WAIT_ACK` on a request without acknowledge.
- `PH_IDLE`→`PH_HOLD` on request and acknowledge together.
- `PH_WAIT_ACK`→`PH_HOLD` on acknowledge.
- `PH_WAIT_ACK`→`PH_RESP_LATE` on the response limit being hit.
- `PH_RESP_LATE`→`PH_HOLD` on acknowledge.
- `PH_HOLD`→`PH_HOLD_OVER` on the hold limit being hit.
- Any state→`PH_IDLE` when the request is sampled low.

Top module: `phm_timing_monitor`

## Requirements
- R1: Let the request first be sampled high on edge E0. With a response limit L other than 0, if the acknowledge is still sampled low on edge E0+L, status bit 1 is set from the following cycle. An acknowledge sampled high on or before E0+L sets nothing.
- R2: Let the acknowledge first be sampled high on edge H0. With a hold limit L other than 0, if the request is still sampled high on edge H0+L, status bit 0 is set from the following cycle. A request sampled low on or before H0+L sets nothing.
- R3: A limit of zero disables its check, so no handshake length sets the matching status bit.
- R4: A limit write with copy index c loads copy c. Data bits 15:0 are the hold limit and bits 31:16 are the response limit. After reset all limits in all copies are zero.
- R5: The copy whose limits apply is the value of the select input on edge E0. Changes of the select during the handshake have no effect.
- R6: Status bits stay set until a clear write has a one in that bit position (mask bit 0 clears the hold bit, mask bit 1 the response bit). A violation and a clear of the same bit on the same edge leaves the bit set.
- R7: The interrupt output is high exactly when at least one status bit is set.
- R8: Each check flags at most once per request. Once flagged, clearing the bit while the request is still high does not set it again.
- R9: Sampling the request low returns the monitor to idle and clears both counters, so the next request is timed from zero.
- R10: After reset both status bits and the interrupt are low.
- R11: A late acknowledge still starts the hold check, so one request can set both bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | DFI clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| phy_req_i | input | 1 | Request for interface ownership from the PHY side |
| ctrl_ack_i | input | 1 | Acknowledge from the controller |
| freq_sel_i | input | SEL_W | Frequency copy in use, sampled when a request starts |
| lim_wr_en_i | input | 1 | Limit register write strobe |
| lim_wr_copy_i | input | SEL_W | Copy index of the limit write |
| lim_wr_data_i | input | 2*LIM_W | Limit word: hold limit low half, response limit high half |
| err_clr_en_i | input | 1 | Status clear strobe |
| err_clr_mask_i | input | 2 | Write-one-to-clear mask for the status bits |
| err_status_o | output | 2 | Sticky status: bit 0 hold violation, bit 1 response violation |
| irq_o | output | 1 | Interrupt, high while any status bit is set |

## Verification
The situation hardest to reach from the ports is a flag that lands on exactly the limit edge. This matters most when a clear write arrives on that same edge, or when the bit is cleared while the sequencer sits in a post-violation state with the request still high. The stimulus reaches these cases by driving the request and acknowledge from the falling edge with delays counted in edges from E0 and H0. This places acknowledges and request drops at L and L+1, and puts a clear strobe onto edge H0+L. Random handshakes with random limits, copies and select flips then cover the response and hold combinations around those boundaries.

// File: rtl/phm_pkg.sv
package phm_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_WAIT_ACK,
        PH_RESP_LATE,
        PH_HOLD,
        PH_HOLD_OVER
    } phm_state_e;

    localparam int unsigned ERR_HOLD_BIT = 0;
    localparam int unsigned ERR_RESP_BIT = 1;
    localparam int unsigned ERR_W        = 2;

endpackage

// File: rtl/phm_limit_bank.sv
module phm_limit_bank #(
    parameter int LIM_W  = 16,
    parameter int N_COPY = 2,
    parameter int SEL_W  = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [SEL_W-1:0]   wr_copy,
    input  logic [2*LIM_W-1:0] wr_data,
    input  logic [SEL_W-1:0]   rd_copy,
    output logic [LIM_W-1:0]   hold_lim,
    output logic [LIM_W-1:0]   resp_lim
);

    logic [N_COPY-1:0][LIM_W-1:0] hold_all;
    logic [N_COPY-1:0][LIM_W-1:0] resp_all;

    for (genvar g = 0; g < N_COPY; g++) begin : g_copy
        logic [LIM_W-1:0] hold_r;
        logic [LIM_W-1:0] resp_r;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                hold_r <= '0;
                resp_r <= '0;
            end else if (wr_en && (wr_copy == SEL_W'(g))) begin
                hold_r <= wr_data[LIM_W-1:0];
                resp_r <= wr_data[2*LIM_W-1:LIM_W];
            end
        end

        assign hold_all[g] = hold_r;
        assign resp_all[g] = resp_r;
    end

    always_comb begin
        hold_lim = '0;
        resp_lim = '0;
        for (int c = 0; c < N_COPY; c++) begin
            if (rd_copy == SEL_W'(c)) begin
                hold_lim = hold_all[c];
                resp_lim = resp_all[c];
            end
        end
    end

endmodule

// File: rtl/phm_handshake_fsm.sv
module phm_handshake_fsm
    import phm_pkg::*;
#(
    parameter int LIM_W = 16,
    parameter int SEL_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             ack,
    input  logic [SEL_W-1:0] sel_in,
    input  logic [LIM_W-1:0] hold_lim,
    input  logic [LIM_W-1:0] resp_lim,
    output logic [SEL_W-1:0] sel_q,
    output phm_state_e       state,
    output logic             resp_viol,
    output logic             hold_viol
);

    localparam logic [LIM_W-1:0] CNT_MAX = '1;

    phm_state_e       state_nxt;
    logic [LIM_W-1:0] resp_cnt;
    logic [LIM_W-1:0] hold_cnt;
    logic [LIM_W-1:0] resp_inc;
    logic [LIM_W-1:0] hold_inc;
    logic             resp_hit;
    logic             hold_hit;

    assign resp_inc = resp_cnt + 1'b1;
    assign hold_inc = hold_cnt + 1'b1;
    assign resp_hit = (resp_lim != '0) && (resp_cnt != CNT_MAX) && (resp_inc == resp_lim);
    assign hold_hit = (hold_lim != '0) && (hold_cnt != CNT_MAX) && (hold_inc == hold_lim);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= PH_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // next-state selection
    always_comb begin
        state_nxt = state;
        unique case (state)
            PH_IDLE: begin
                if (req) begin
                    state_nxt = ack ? PH_HOLD : PH_WAIT_ACK;
                end
            end
            PH_WAIT_ACK: begin
                if (!req) begin
                    state_nxt = PH_IDLE;
                end else if (ack) begin
                    state_nxt = PH_HOLD;
                end else if (resp_hit) begin
                    state_nxt = PH_RESP_LATE;
                end
            end
            PH_RESP_LATE: begin
                if (!req) begin
                    state_nxt = PH_IDLE;
                end else if (ack) begin
                    state_nxt = PH_HOLD;
                end
            end
            PH_HOLD: begin
                if (!req) begin
                    state_nxt = PH_IDLE;
                end else if (hold_hit) begin
                    state_nxt = PH_HOLD_OVER;
                end
            end
            PH_HOLD_OVER: begin
                if (!req) begin
                    state_nxt = PH_IDLE;
                end
            end
            default: state_nxt = PH_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        resp_viol = 1'b0;
        hold_viol = 1'b0;
        unique case (state)
            PH_WAIT_ACK:  resp_viol = req && !ack && resp_hit;
            PH_HOLD:      hold_viol = req && hold_hit;
            PH_IDLE, PH_RESP_LATE, PH_HOLD_OVER: begin
                resp_viol = 1'b0;
                hold_viol = 1'b0;
            end
            default: begin
                resp_viol = 1'b0;
                hold_viol = 1'b0;
            end
        endcase
    end

    // phase counters and copy latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            resp_cnt <= '0;
            hold_cnt <= '0;
            sel_q    <= '0;
        end else begin
            if (state == PH_IDLE && req) begin
                sel_q <= sel_in;
            end
            if (state != PH_WAIT_ACK) begin
                resp_cnt <= '0;
            end else if (req && !ack && resp_cnt != CNT_MAX) begin
                resp_cnt <= resp_inc;
            end
            if (state != PH_HOLD) begin
                hold_cnt <= '0;
            end else if (req && hold_cnt != CNT_MAX) begin
                hold_cnt <= hold_inc;
            end
        end
    end

endmodule

// File: rtl/phm_err_status.sv
module phm_err_status #(
    parameter int ERR_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ERR_W-1:0] set_vec,
    input  logic             clr_en,
    input  logic [ERR_W-1:0] clr_mask,
    output logic [ERR_W-1:0] status
);

    for (genvar b = 0; b < ERR_W; b++) begin : g_bit
        logic bit_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bit_q <= 1'b0;
            end else if (set_vec[b]) begin
                bit_q <= 1'b1;
            end else if (clr_en && clr_mask[b]) begin
                bit_q <= 1'b0;
            end
        end

        assign status[b] = bit_q;
    end

endmodule

// File: rtl/phm_timing_monitor.sv
module phm_timing_monitor
    import phm_pkg::*;
#(
    parameter int LIM_W  = 16,
    parameter int N_COPY = 2,
    localparam int SEL_W = (N_COPY > 1) ? $clog2(N_COPY) : 1
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               phy_req_i,
    input  logic               ctrl_ack_i,
    input  logic [SEL_W-1:0]   freq_sel_i,
    input  logic               lim_wr_en_i,
    input  logic [SEL_W-1:0]   lim_wr_copy_i,
    input  logic [2*LIM_W-1:0] lim_wr_data_i,
    input  logic               err_clr_en_i,
    input  logic [1:0]         err_clr_mask_i,
    output logic [1:0]         err_status_o,
    output logic               irq_o
);

    logic [SEL_W-1:0] sel_active;
    logic [LIM_W-1:0] hold_lim_sel;
    logic [LIM_W-1:0] resp_lim_sel;
    logic             resp_viol;
    logic             hold_viol;
    phm_state_e       fsm_state;
    logic [ERR_W-1:0] viol_vec;

    phm_limit_bank #(
        .LIM_W  (LIM_W),
        .N_COPY (N_COPY),
        .SEL_W  (SEL_W)
    ) u_bank (
        .clk      (clk_i),
        .rst_n    (rst_ni),
        .wr_en    (lim_wr_en_i),
        .wr_copy  (lim_wr_copy_i),
        .wr_data  (lim_wr_data_i),
        .rd_copy  (sel_active),
        .hold_lim (hold_lim_sel),
        .resp_lim (resp_lim_sel)
    );

    phm_handshake_fsm #(
        .LIM_W (LIM_W),
        .SEL_W (SEL_W)
    ) u_fsm (
        .clk       (clk_i),
        .rst_n     (rst_ni),
        .req       (phy_req_i),
        .ack       (ctrl_ack_i),
        .sel_in    (freq_sel_i),
        .hold_lim  (hold_lim_sel),
        .resp_lim  (resp_lim_sel),
        .sel_q     (sel_active),
        .state     (fsm_state),
        .resp_viol (resp_viol),
        .hold_viol (hold_viol)
    );

    always_comb begin
        viol_vec               = '0;
        viol_vec[ERR_HOLD_BIT] = hold_viol;
        viol_vec[ERR_RESP_BIT] = resp_viol;
    end

    phm_err_status #(
        .ERR_W (ERR_W)
    ) u_status (
        .clk      (clk_i),
        .rst_n    (rst_ni),
        .set_vec  (viol_vec),
        .clr_en   (err_clr_en_i),
        .clr_mask (err_clr_mask_i),
        .status   (err_status_o)
    );

    assign irq_o = |err_status_o;

endmodule

// File: rtl/phm_monitor_chk.sv
module phm_monitor_chk
    import phm_pkg::*;
#(
    parameter int LIM_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req,
    input logic [1:0]       status,
    input logic             irq,
    input logic             clr_en,
    input logic [1:0]       clr_mask,
    input logic             resp_viol,
    input logic             hold_viol,
    input logic [LIM_W-1:0] resp_lim,
    input logic [LIM_W-1:0] hold_lim,
    input phm_state_e       state
);

    // R1
    resp_sets_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_viol |=> status[1]);

    // R2
    hold_sets_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_viol |=> status[0]);

    // R3
    resp_zero_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_viol |-> (resp_lim != '0));

    // R3
    hold_zero_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_viol |-> (hold_lim != '0));

    // R6
    hold_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status[0] && !(clr_en && clr_mask[0])) |=> status[0]);

    // R6
    resp_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status[1] && !(clr_en && clr_mask[1])) |=> status[1]);

    // R7
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(resp_viol || hold_viol));

    // R8
    single_hold_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_viol |=> (!hold_viol && (!req || state == PH_HOLD_OVER)));

    // R9
    drop_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!req && state != PH_IDLE) |=> (state == PH_IDLE));

endmodule

bind phm_timing_monitor phm_monitor_chk #(
    .LIM_W (LIM_W)
) u_monitor_chk (
    .clk       (clk_i),
    .rst_n     (rst_ni),
    .req       (phy_req_i),
    .status    (err_status_o),
    .irq       (irq_o),
    .clr_en    (err_clr_en_i),
    .clr_mask  (err_clr_mask_i),
    .resp_viol (resp_viol),
    .hold_viol (hold_viol),
    .resp_lim  (resp_lim_sel),
    .hold_lim  (hold_lim_sel),
    .state     (fsm_state)
);

// File: tb/test_phm_timing_monitor.sv
`timescale 1ns/1ps
module test_phm_timing_monitor;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        ack = 1'b0;
    logic [0:0]  fsel = 1'b0;
    logic        cfg_we = 1'b0;
    logic [0:0]  cfg_copy = 1'b0;
    logic [31:0] cfg_data = '0;
    logic        clr_en = 1'b0;
    logic [1:0]  clr_mask = '0;
    logic [1:0]  status;
    logic        irq;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    int lim_h [2];
    int lim_r [2];

    always #2.5 clk = ~clk;

    phm_timing_monitor i_phm_timing_monitor (
        .clk_i          (clk),
        .rst_ni         (rst_n),
        .phy_req_i      (req),
        .ctrl_ack_i     (ack),
        .freq_sel_i     (fsel),
        .lim_wr_en_i    (cfg_we),
        .lim_wr_copy_i  (cfg_copy),
        .lim_wr_data_i  (cfg_data),
        .err_clr_en_i   (clr_en),
        .err_clr_mask_i (clr_mask),
        .err_status_o   (status),
        .irq_o          (irq)
    );

    function automatic logic [1:0] expect_bits(input int f, input int d, input int k);
        logic [1:0] e;
        e[1] = (lim_r[f] != 0) && (d > lim_r[f]);
        e[0] = (lim_h[f] != 0) && (k > lim_h[f]);
        return e;
    endfunction

    task automatic check_st(input logic [1:0] exp, input string tag);
        checks++;
        if (status !== exp || irq !== (|exp)) begin
            fails++;
            $display("FAIL %s: status=%b irq=%b expected status=%b irq=%b",
                     tag, status, irq, exp, |exp);
        end
    endtask

    task automatic write_lim(input int c, input int hold, input int resp);
        @(negedge clk);
        cfg_we   = 1'b1;
        cfg_copy = c[0:0];
        cfg_data = {resp[15:0], hold[15:0]};
        @(negedge clk);
        cfg_we   = 1'b0;
        lim_h[c] = hold;
        lim_r[c] = resp;
    endtask

    task automatic clear_bits(input logic [1:0] m);
        @(negedge clk);
        clr_en   = 1'b1;
        clr_mask = m;
        @(negedge clk);
        clr_en   = 1'b0;
        clr_mask = '0;
    endtask

    // d: edges from E0 to the acknowledge sample; k: edges from H0 to the request-low sample
    task automatic run_hs(input int f, input int d, input int k, input bit flip);
        @(negedge clk);
        req  = 1'b1;
        fsel = f[0:0];
        ack  = (d == 0);
        for (int j = 1; j <= d; j++) begin
            @(negedge clk);
            if (flip) fsel = ~f[0:0];
            if (j == d) ack = 1'b1;
        end
        for (int j = 1; j <= k; j++) begin
            @(negedge clk);
            if (flip) fsel = ~f[0:0];
        end
        req = 1'b0;
        ack = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic summary();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7321));
        lim_h[0] = 0; lim_h[1] = 0; lim_r[0] = 0; lim_r[1] = 0;
        repeat (3) @(negedge clk);
        check_st(2'b00, "R10 status during reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_st(2'b00, "R10 status after reset");

        // R4: reset limits are zero, so long handshakes flag nothing
        run_hs(0, 20, 20, 1'b0);
        check_st(2'b00, "R4 copy0 reset limits zero");
        run_hs(1, 20, 20, 1'b0);
        check_st(2'b00, "R4 copy1 reset limits zero");

        write_lim(0, 3, 4);
        write_lim(1, 6, 2);

        // R1 boundaries
        run_hs(0, 4, 1, 1'b0);
        check_st(2'b00, "R1 ack at limit edge");
        run_hs(0, 5, 1, 1'b0);
        check_st(2'b10, "R1 ack one edge late");
        clear_bits(2'b11);
        check_st(2'b00, "R6 clear both");

        // R2 boundaries
        run_hs(0, 0, 3, 1'b0);
        check_st(2'b00, "R2 drop at limit edge");
        run_hs(0, 1, 4, 1'b0);
        check_st(2'b01, "R2 drop one edge late");
        clear_bits(2'b01);

        // R4 field layout on copy1
        run_hs(1, 2, 6, 1'b0);
        check_st(2'b00, "R4 copy1 within limits");
        run_hs(1, 3, 7, 1'b0);
        check_st(2'b11, "R4 R11 copy1 both late");
        clear_bits(2'b01);
        check_st(2'b10, "R6 partial clear keeps bit 1");
        clear_bits(2'b10);
        check_st(2'b00, "R6 clear bit 1");

        // R5: select flips during the handshake are ignored
        run_hs(0, 3, 5, 1'b1);
        check_st(expect_bits(0, 3, 5), "R5 select flipped mid handshake");
        clear_bits(2'b11);
        run_hs(1, 3, 5, 1'b1);
        check_st(expect_bits(1, 3, 5), "R5 copy1 select flipped");
        clear_bits(2'b11);

        // R3: zero disables one check while the other stays active
        write_lim(0, 0, 4);
        run_hs(0, 30, 30, 1'b0);
        check_st(2'b10, "R3 hold limit zero");
        clear_bits(2'b11);
        write_lim(0, 3, 0);
        run_hs(0, 30, 30, 1'b0);
        check_st(2'b01, "R3 response limit zero");
        clear_bits(2'b11);

        // R6: violation and clear on the same edge
        write_lim(0, 3, 4);
        @(negedge clk);
        req = 1'b1; ack = 1'b1; fsel = 1'b0;
        repeat (3) @(negedge clk);
        clr_en = 1'b1; clr_mask = 2'b01;
        @(negedge clk);
        clr_en = 1'b0; clr_mask = 2'b00;
        check_st(2'b01, "R6 set wins over same-edge clear");
        req = 1'b0; ack = 1'b0;
        clear_bits(2'b11);

        // R8: no second flag after clearing in the post-violation state
        write_lim(0, 2, 4);
        @(negedge clk);
        req = 1'b1; ack = 1'b1; fsel = 1'b0;
        repeat (4) @(negedge clk);
        check_st(2'b01, "R8 hold flagged");
        clear_bits(2'b01);
        repeat (5) @(negedge clk);
        check_st(2'b00, "R8 hold not flagged again");
        req = 1'b0; ack = 1'b0;
        repeat (2) @(negedge clk);
        @(negedge clk);
        req = 1'b1; ack = 1'b0;
        repeat (6) @(negedge clk);
        check_st(2'b10, "R8 response flagged");
        clear_bits(2'b10);
        repeat (6) @(negedge clk);
        check_st(2'b00, "R8 response not flagged again");
        ack = 1'b1;
        @(negedge clk);
        req = 1'b0; ack = 1'b0;
        repeat (2) @(negedge clk);
        check_st(2'b00, "R8 R11 hold check after late ack");

        // R9: counters restart on every request
        write_lim(0, 5, 5);
        for (int n = 0; n < 3; n++) begin
            @(negedge clk);
            req = 1'b1; ack = 1'b0;
            repeat (4) @(negedge clk);
            req = 1'b0;
            @(negedge clk);
        end
        check_st(2'b00, "R9 aborted requests restart count");
        run_hs(0, 5, 4, 1'b0);
        run_hs(0, 4, 5, 1'b0);
        check_st(2'b00, "R9 back-to-back handshakes");

        // R1 with a wide limit
        write_lim(1, 0, 300);
        run_hs(1, 300, 2, 1'b0);
        check_st(2'b00, "R1 wide limit on edge");
        run_hs(1, 301, 2, 1'b0);
        check_st(2'b10, "R1 wide limit exceeded");
        clear_bits(2'b11);

        // random handshakes: R1 R2 R3 R5 R7 R11
        for (int it = 0; it < 120; it++) begin
            int f;
            int d;
            int k;
            bit flip;
            if (($urandom % 4) == 0) begin
                int c;
                int h;
                int r;
                c = $urandom % 2;
                h = (($urandom % 4) == 0) ? 0 : 1 + ($urandom % 6);
                r = (($urandom % 4) == 0) ? 0 : 1 + ($urandom % 6);
                write_lim(c, h, r);
            end
            f    = $urandom % 2;
            d    = $urandom % 9;
            k    = 1 + ($urandom % 8);
            flip = $urandom % 2;
            run_hs(f, d, k, flip);
            check_st(expect_bits(f, d, k), "R1 R2 R3 R5 R7 R11 random handshake");
            clear_bits(2'b11);
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule